// File: doc/BRIEF.md
# Paired-Channel Simultaneous-Sampling Converter Readout

This block models the digital side of a six-channel converter. The channels are grouped into three pairs, and each pair has its own active-low start input. A start pulse is a low level followed by a return to high. The rising edge captures the present sample values of the pair into hold registers. It also raises a busy flag for a fixed number of clock cycles, which models the converter's internal timebase. When busy drops, the held values move into the result registers and the converter returns to tracking. Driving all three start inputs together samples all six channels at once. Channel values come from a flat input bus, with channel 1 in the least significant field.

Results leave the block through one of two paths. In parallel mode a chip-select-qualified read strobe steps through the channels of the last conversion only, in ascending order. Each strobe returns either a whole 16-bit word or one byte, high byte first. In serial mode each strobe shifts out one bit, most significant bit first, through all six channels in order. Channels that took no part in the last conversion send zeros. A new conversion start resets the read position to the beginning.

Top module: `adc6_readout`

## Requirements
- R1: After reset, busy_o, dout_o and sdata_o are all 0.
- R2: A 0-to-1 transition on any bit of conv_start_i while busy_o is low makes busy_o high from the next clock for exactly CONV_CYCLES cycles. Bit 0 selects channels 1 and 2, bit 1 selects channels 3 and 4, and bit 2 selects channels 5 and 6.
- R3: Start transitions that arrive while busy_o is high are ignored. They neither extend busy nor add their pair to the conversion in progress.
- R4: Transitions on several start bits in the same clock convert all of those pairs in one conversion, and their channels are all read out.
- R5: In parallel word mode (ser_sel_i=0, byte_sel_i=0), each accepted read returns the next converted channel in ascending channel order on dout_o, starting from the clock after the strobe.
- R6: In parallel byte mode (byte_sel_i=1), each channel takes two accepted reads. The first returns bits 15:8 and the second returns bits 7:0, both in dout_o[7:0], with dout_o[15:8] at zero.
- R7: Parallel reads past the last converted channel return zero and do not wrap to the first channel.
- R8: In serial mode (ser_sel_i=1), each accepted read puts the next bit on sdata_o, MSB first, for channels 1 to 6 in order. Channels that were not converted give zero bits, reads past 96 bits give 0, and dout_o holds its value.
- R9: A read is accepted only when rd_i=1, cs_n_i=0 and busy_o=0. Any other strobe changes no output and does not advance the read position.
- R10: An accepted conversion start resets the read position to the first channel or bit.
- R11: The result of a channel is the sample_i value present on the clock of its start transition. Later changes during busy do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_start_i | input | 3 | Active-low start pulse, one bit per channel pair |
| sample_i | input | 96 | Six 16-bit channel values, channel 1 in bits 15:0 |
| ser_sel_i | input | 1 | Interface select: 0 parallel, 1 serial |
| byte_sel_i | input | 1 | Parallel access size: 0 word, 1 byte |
| cs_n_i | input | 1 | Active-low chip select for reads |
| rd_i | input | 1 | One-cycle read strobe |
| busy_o | output | 1 | High while a conversion is in progress |
| dout_o | output | 16 | Parallel read data |
| sdata_o | output | 1 | Serial read data bit |

## Verification
The bench targets a second start edge during busy. A design that merges it would stretch busy or return the late pair's channels. Sample values are changed during a conversion, so a design that latches at the end of busy would show the wrong data. The bench also reads past the last converted channel in word, byte and serial modes, where a wrapping pointer would repeat channel data instead of zeros. It interleaves strobes with chip select high and strobes during busy, which a careless qualifier would count. Finally it starts a new conversion after a partial readout, where a stale pointer would skip channels.

// File: rtl/adc6_pkg.sv
package adc6_pkg;
  localparam int unsigned CH_PER_PAIR = 2;
  localparam int unsigned N_PAIRS     = 3;
  localparam int unsigned N_CH        = N_PAIRS * CH_PER_PAIR;

  typedef enum logic {
    IF_PARALLEL = 1'b0,
    IF_SERIAL   = 1'b1
  } if_mode_e;
endpackage

// File: rtl/adc6_start_detect.sv
module adc6_start_detect #(
  parameter int unsigned N_PAIRS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PAIRS-1:0] start_i,
  output logic [N_PAIRS-1:0] rise_o
);
  logic [N_PAIRS-1:0] prev_q;
  logic [N_PAIRS-1:0] prev_d;

  always_comb prev_d = start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_edge
    assign rise_o[p] = start_i[p] & ~prev_q[p];
  end
endmodule

// File: rtl/adc6_conv_timer.sv
module adc6_conv_timer #(
  parameter int unsigned CONV_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_rise_i,
  output logic accept_o,
  output logic done_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept_o = any_rise_i & ~busy_q;
  assign busy_o   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_o = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/adc6_result_bank.sv
module adc6_result_bank #(
  parameter int unsigned N_PAIRS     = 3,
  parameter int unsigned CH_PER_PAIR = 2,
  parameter int unsigned DATA_W      = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            accept_i,
  input  logic                            done_i,
  input  logic [N_PAIRS-1:0]              rise_i,
  input  logic [N_PAIRS*CH_PER_PAIR*DATA_W-1:0] sample_i,
  output logic [N_PAIRS*CH_PER_PAIR*DATA_W-1:0] res_o,
  output logic [N_PAIRS-1:0]              mask_o
);
  localparam int unsigned N_CH = N_PAIRS * CH_PER_PAIR;

  logic [N_PAIRS-1:0] sel_q, sel_d;
  logic [N_PAIRS-1:0] mask_q, mask_d;

  always_comb begin
    sel_d  = accept_i ? rise_i : sel_q;
    mask_d = done_i   ? sel_q  : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= '0;
    end else begin
      sel_q  <= sel_d;
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned PAIR = ch / CH_PER_PAIR;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic [DATA_W-1:0] res_q, res_d;

    always_comb begin
      hold_d = hold_q;
      if (accept_i && rise_i[PAIR]) hold_d = sample_i[ch*DATA_W +: DATA_W];
      res_d = res_q;
      if (done_i) res_d = sel_q[PAIR] ? hold_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        res_q  <= '0;
      end else begin
        hold_q <= hold_d;
        res_q  <= res_d;
      end
    end

    assign res_o[ch*DATA_W +: DATA_W] = res_q;
  end
endmodule

// File: rtl/adc6_read_seq.sv
module adc6_read_seq #(
  parameter int unsigned N_PAIRS     = 3,
  parameter int unsigned CH_PER_PAIR = 2,
  parameter int unsigned DATA_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N_PAIRS*CH_PER_PAIR*DATA_W-1:0] res_i,
  input  logic [N_PAIRS-1:0]                    mask_i,
  input  logic                                  clr_i,
  input  logic                                  rd_en_i,
  input  logic                                  ser_sel_i,
  input  logic                                  byte_sel_i,
  output logic [DATA_W-1:0]                     dout_o,
  output logic                                  sdata_o
);
  localparam int unsigned N_CH    = N_PAIRS * CH_PER_PAIR;
  localparam int unsigned SER_LEN = N_CH * DATA_W;
  localparam int unsigned PTR_W   = $clog2(SER_LEN + 1);
  localparam int unsigned LO_W    = DATA_W / 2;
  localparam int unsigned HI_W    = DATA_W - LO_W;

  logic [PTR_W-1:0]  ptr_q, ptr_d, slot;
  logic [DATA_W-1:0] pick, par_val;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              ser_bit, sdata_q, sdata_d;

  always_comb slot = byte_sel_i ? (ptr_q >> 1) : ptr_q;

  // Select the slot-th converted channel in ascending order.
  always_comb begin : slot_pick
    logic [PTR_W-1:0] seen;
    seen = '0;
    pick = '0;
    for (int ch = 0; ch < int'(N_CH); ch++) begin
      if (mask_i[ch / CH_PER_PAIR]) begin
        if (seen == slot) pick = res_i[ch*DATA_W +: DATA_W];
        seen = seen + PTR_W'(1);
      end
    end
  end

  always_comb begin
    if (!byte_sel_i)   par_val = pick;
    else if (ptr_q[0]) par_val = {{HI_W{1'b0}}, pick[LO_W-1:0]};
    else               par_val = {{(DATA_W-HI_W){1'b0}}, pick[DATA_W-1:LO_W]};
  end

  // Serial stream: channel 1 first, each channel MSB first.
  always_comb begin : ser_pick
    ser_bit = 1'b0;
    for (int i = 0; i < int'(SER_LEN); i++) begin
      if (ptr_q == PTR_W'(i))
        ser_bit = res_i[(i / DATA_W) * DATA_W + DATA_W - 1 - (i % DATA_W)];
    end
  end

  always_comb begin
    ptr_d   = ptr_q;
    dout_d  = dout_q;
    sdata_d = sdata_q;
    if (clr_i) begin
      ptr_d = '0;
    end else if (rd_en_i) begin
      if (ptr_q != '1) ptr_d = ptr_q + PTR_W'(1);
      if (ser_sel_i) sdata_d = ser_bit;
      else           dout_d  = par_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      dout_q  <= '0;
      sdata_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      dout_q  <= dout_d;
      sdata_q <= sdata_d;
    end
  end

  assign dout_o  = dout_q;
  assign sdata_o = sdata_q;
endmodule

// File: rtl/adc6_readout.sv
module adc6_readout #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 300
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [adc6_pkg::N_PAIRS-1:0]             conv_start_i,
  input  logic [adc6_pkg::N_CH*DATA_W-1:0]         sample_i,
  input  logic                                     ser_sel_i,
  input  logic                                     byte_sel_i,
  input  logic                                     cs_n_i,
  input  logic                                     rd_i,
  output logic                                     busy_o,
  output logic [DATA_W-1:0]                        dout_o,
  output logic                                     sdata_o
);
  import adc6_pkg::*;

  logic                rst_sync_q1, rst_sync_q2;
  logic                rst_n_int;
  logic [N_PAIRS-1:0]  rise;
  logic                accept, done, busy;
  logic                rd_en;
  logic [N_CH*DATA_W-1:0] res;
  logic [N_PAIRS-1:0]  mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end
  assign rst_n_int = rst_sync_q2;

  adc6_start_detect #(.N_PAIRS(N_PAIRS)) u_start (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (conv_start_i),
    .rise_o  (rise)
  );

  adc6_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .any_rise_i (|rise),
    .accept_o   (accept),
    .done_o     (done),
    .busy_o     (busy)
  );

  adc6_result_bank #(
    .N_PAIRS     (N_PAIRS),
    .CH_PER_PAIR (CH_PER_PAIR),
    .DATA_W      (DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .accept_i (accept),
    .done_i   (done),
    .rise_i   (rise),
    .sample_i (sample_i),
    .res_o    (res),
    .mask_o   (mask)
  );

  assign rd_en = rd_i & ~cs_n_i & ~busy;

  adc6_read_seq #(
    .N_PAIRS     (N_PAIRS),
    .CH_PER_PAIR (CH_PER_PAIR),
    .DATA_W      (DATA_W)
  ) u_read (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .res_i      (res),
    .mask_i     (mask),
    .clr_i      (accept),
    .rd_en_i    (rd_en),
    .ser_sel_i  (ser_sel_i == IF_SERIAL),
    .byte_sel_i (byte_sel_i),
    .dout_o     (dout_o),
    .sdata_o    (sdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/adc6_readout_chk.sv
module adc6_readout_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        conv_start_i,
  input logic              ser_sel_i,
  input logic              byte_sel_i,
  input logic              cs_n_i,
  input logic              rd_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] dout_o,
  input logic              sdata_o
);
  logic [2:0] prev_q;
  int unsigned run_q;
  logic rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      run_q  <= 0;
    end else begin
      prev_q <= conv_start_i;
      run_q  <= busy_o ? run_q + 1 : 0;
    end
  end

  assign rd_ok = rd_i && !cs_n_i && !busy_o;

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && |(conv_start_i & ~prev_q)) |=> busy_o);

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && run_q != 0) |-> run_q == CONV_CYCLES);

  // R3
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_q < CONV_CYCLES);

  // R9
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || cs_n_i || !rd_i) |=> ($stable(dout_o) && $stable(sdata_o)));

  // R6
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !ser_sel_i && byte_sel_i) |=> dout_o[DATA_W-1:DATA_W/2] == '0);

  // R8
  ser_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && ser_sel_i) |=> $stable(dout_o));
endmodule

bind adc6_readout adc6_readout_chk #(
  .DATA_W      (DATA_W),
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start_i (conv_start_i),
  .ser_sel_i    (ser_sel_i),
  .byte_sel_i   (byte_sel_i),
  .cs_n_i       (cs_n_i),
  .rd_i         (rd_i),
  .busy_o       (busy_o),
  .dout_o       (dout_o),
  .sdata_o      (sdata_o)
);

// File: tb/adc6_readout_bench.sv
module adc6_readout_bench;
  localparam int DW   = 16;
  localparam int NCH  = 6;
  localparam int CONV = 12;

  logic clk;
  logic rst_n;
  logic [2:0]        conv_start;
  logic [NCH*DW-1:0] samples;
  logic ser_sel, byte_sel, cs_n, rd;
  logic busy;
  logic [DW-1:0] dout;
  logic sdata;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit compare_on = 0;
  bit finished = 0;

  adc6_readout #(.DATA_W(DW), .CONV_CYCLES(CONV)) u_adc6_readout (
    .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start), .sample_i(samples),
    .ser_sel_i(ser_sel), .byte_sel_i(byte_sel), .cs_n_i(cs_n), .rd_i(rd),
    .busy_o(busy), .dout_o(dout), .sdata_o(sdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference model
  bit          m_busy;
  int          m_left;
  bit [2:0]    m_prev, m_mask;
  logic [15:0] m_hold [NCH];
  int unsigned m_par [$];
  bit          m_ser [$];
  int          m_ptr;
  logic [15:0] m_dout;
  bit          m_sd;

  always @(posedge clk or negedge rst_n) begin
    bit [2:0] rise;
    int unsigned v;
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_prev = 3'b111; m_mask = 0; m_ptr = 0;
      m_dout = 0; m_sd = 0; m_par.delete(); m_ser.delete();
      for (int c = 0; c < NCH; c++) m_hold[c] = 0;
    end else begin
      rise = conv_start & ~m_prev;
      m_prev = conv_start;
      if (!m_busy) begin
        if (rise != 0) begin
          m_busy = 1; m_left = CONV; m_mask = rise; m_ptr = 0;
          for (int c = 0; c < NCH; c++)
            if (rise[c/2]) m_hold[c] = samples[c*DW +: DW];
        end else if (rd && !cs_n) begin
          if (ser_sel) begin
            m_sd = (m_ptr < m_ser.size()) ? m_ser[m_ptr] : 1'b0;
          end else if (!byte_sel) begin
            m_dout = (m_ptr < m_par.size()) ? 16'(m_par[m_ptr]) : 16'h0;
          end else begin
            v = (m_ptr/2 < m_par.size()) ? m_par[m_ptr/2] : 0;
            m_dout = (m_ptr % 2 == 0) ? 16'((v >> 8) & 255) : 16'(v & 255);
          end
          m_ptr++;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_par.delete(); m_ser.delete();
          for (int c = 0; c < NCH; c++) begin
            if (m_mask[c/2]) m_par.push_back(m_hold[c]);
            for (int b = DW-1; b >= 0; b--)
              m_ser.push_back(m_mask[c/2] ? m_hold[c][b] : 1'b0);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !finished) begin
      check(busy === m_busy, "busy_o", int'(busy), int'(m_busy));
      check(dout === m_dout, "dout_o", int'(dout), int'(m_dout));
      check(sdata === m_sd,  "sdata_o", int'(sdata), int'(m_sd));
    end
  end

  task automatic start_pulse(input bit [2:0] m);
    @(negedge clk) conv_start = ~m;
    @(negedge clk);
    @(negedge clk) conv_start = 3'b111;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reads(input int n, input bit csn);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin rd = 1; cs_n = csn; end
    end
    @(negedge clk) begin rd = 0; cs_n = 1; end
  endtask

  task automatic load_samples(input int seed);
    for (int c = 0; c < NCH; c++)
      samples[c*DW +: DW] = 16'((c + 1) * 16'h1111 ^ (seed * 16'h0357));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 0; conv_start = 3'b111; ser_sel = 0; byte_sel = 0; cs_n = 1; rd = 0;
    load_samples(1);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset values
    cur_req = "R1";
    check(busy === 1'b0, "reset busy", int'(busy), 0);
    check(dout === 16'h0, "reset dout", int'(dout), 0);
    check(sdata === 1'b0, "reset sdata", int'(sdata), 0);
    compare_on = 1;

    // R2: pair A alone, busy width
    cur_req = "R2";
    start_pulse(3'b001);
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    check(n == CONV, "busy width", n, CONV);
    // R5 and R7: word reads, then past the end
    cur_req = "R5";
    reads(2, 0);
    cur_req = "R7";
    reads(3, 0);

    // R4: all three pairs together, word reads past end
    cur_req = "R4";
    load_samples(2);
    start_pulse(3'b111);
    wait_idle();
    reads(7, 0);

    // R3 and R11: late start on B during busy, samples change during busy
    cur_req = "R3";
    load_samples(3);
    start_pulse(3'b001);
    cur_req = "R11";
    load_samples(4);
    cur_req = "R3";
    start_pulse(3'b010);
    wait_idle();
    reads(4, 0);

    // R6: byte mode, pairs A and C, with reads past end
    cur_req = "R6";
    byte_sel = 1;
    load_samples(5);
    start_pulse(3'b101);
    wait_idle();
    reads(10, 0);

    // R9: strobes with chip select high, then during busy
    cur_req = "R9";
    byte_sel = 0;
    start_pulse(3'b110);
    reads(3, 0);
    wait_idle();
    reads(2, 1);
    reads(1, 0);
    reads(2, 1);
    reads(4, 0);

    // R10: partial readout, then a new start restarts the sequence
    cur_req = "R10";
    load_samples(6);
    start_pulse(3'b011);
    wait_idle();
    reads(2, 0);
    load_samples(7);
    start_pulse(3'b011);
    wait_idle();
    reads(5, 0);

    // R8: serial readout with pair B only, then past the end
    cur_req = "R8";
    ser_sel = 1;
    load_samples(8);
    start_pulse(3'b010);
    wait_idle();
    reads(100, 0);
    cur_req = "R8";
    load_samples(9);
    start_pulse(3'b101);
    wait_idle();
    reads(40, 0);
    reads(3, 1);
    reads(60, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule